// File: doc/BRIEF.md
# Inter-processor interrupt mailbox controller

This block lets one processing agent raise interrupts towards a group of peer agents and collect interrupts coming back from them. A peer is reached by writing a one into that peer's bit of the trigger word; the matching outbound line then pulses high for a single clock. In the other direction, every peer drives an inbound request line. A request sets a sticky pending bit, which stays set until software clears it by writing a one to it. Pending bits are gated by a per-channel mask, and the gated result is merged into a single interrupt towards the local agent.

The mask cannot be written directly. Software changes it through two separate words: writing ones to the unmask word clears mask bits, and writing ones to the mask-set word sets them. Each pending bit is also driven out on a dedicated per-channel observation output, so that the peers can see which requests have not been serviced yet. A read-only word returns the levels of the peers' own observation lines, sampled once per clock. All accesses are full 32-bit words on a simple strobe bus that has a word address. Read data is registered and appears one clock after the read strobe.

The default configuration has eleven channels. In every register their bits sit at positions 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27, which gives the valid pattern 0x0F0F0301. Channel index k on the per-channel ports corresponds to the k-th lowest valid bit position.

Top module: `ipi_mailbox`

## Requirements
- R1: After synchronous reset the pending word reads 0, the mask word reads 0x0F0F0301 (every channel masked), and irq_out, trig_out and obs_out are all 0.
- R2: The word addresses are: 0 trigger, 1 peer observation, 4 pending, 5 mask, 6 unmask, 7 mask-set. Reading word 2 or word 3 returns 0. Read data appears on bus_rdata on the clock after the read strobe.
- R3: A write to word 0 drives trig_out[k] high for exactly one clock, beginning on the edge that accepts the write, for each channel k whose bit is one. Afterwards trig_out returns to 0, and reading word 0 always gives 0.
- R4: A high level on irq_in[k] at a clock edge sets pending bit k, and the bit stays set after irq_in[k] falls.
- R5: Writing ones to word 4 clears the matching pending bits. Bits written as zero keep their value.
- R6: If irq_in[k] is high on the same edge that software clears pending bit k, the bit stays set.
- R7: Writes to word 5 have no effect on the mask.
- R8: Writing ones to word 6 clears the matching mask bits, and writing ones to word 7 sets them. Both words read back as 0.
- R9: irq_out is a registered output. It is high exactly when some pending bit is set and its mask bit is clear, and it reflects a pending or mask change from the same edge that makes the change.
- R10: Word 1 returns the levels of obs_in, sampled one clock earlier, at the valid bit positions. Writes to word 1 have no effect.
- R11: obs_out[k] equals pending bit k at all times.
- R12: Bits outside 0x0F0F0301 always read as 0, and write data in those bits is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| trig_out | output | NCH | One-cycle outbound trigger pulses |
| irq_in | input | NCH | Inbound interrupt requests, level sampled |
| obs_in | input | NCH | Peer observation levels |
| obs_out | output | NCH | Mirror of the pending bits |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that inputs change only away from the rising edge and that there is at most one access per cycle, with bus_we meaningful only while bus_sel is high. The irq_in and obs_in lines are treated as plain levels that may stay high for any number of cycles. The bench drives every input on the falling edge and deasserts the strobe after each single-cycle access. It holds irq_in high for one cycle, or for a longer stretch in the set-against-clear case.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int BUS_W = 32;

  // word addresses
  localparam int W_TRIG = 0;
  localparam int W_OBS  = 1;
  localparam int W_STAT = 4;
  localparam int W_MASK = 5;
  localparam int W_EN   = 6;
  localparam int W_DIS  = 7;

  // write strobes decoded from the bus
  typedef struct packed {
    logic trig;
    logic stat;
    logic en;
    logic dis;
  } wr_sel_t;

  function automatic int count_set(input logic [BUS_W-1:0] m);
    int n;
    n = 0;
    for (int b = 0; b < BUS_W; b++) begin
      if (m[b]) n++;
    end
    return n;
  endfunction

  // rank of bit b among the set bits of m
  function automatic int rank_of(input logic [BUS_W-1:0] m, input int b);
    int n;
    n = 0;
    for (int i = 0; i < BUS_W; i++) begin
      if (i < b && m[i]) n++;
    end
    return n;
  endfunction

  // position of the k-th set bit of m
  function automatic int nth_set(input logic [BUS_W-1:0] m, input int k);
    int seen;
    int pos;
    seen = 0;
    pos  = 0;
    for (int b = 0; b < BUS_W; b++) begin
      if (m[b]) begin
        if (seen == k) pos = b;
        seen++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode
  import ipi_pkg::*;
#(
  parameter int              ADDR_W     = 3,
  parameter logic [BUS_W-1:0] VALID_MASK = 32'h0F0F0301,
  localparam int             NCH        = count_set(VALID_MASK)
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output wr_sel_t           wr,
  output logic              rd_en,
  output logic [NCH-1:0]    wch
);

  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(W_TRIG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(W_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(W_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(W_DIS);

  logic wr_any;
  assign wr_any  = sel & we;
  assign rd_en   = sel & ~we;

  assign wr.trig = wr_any & (addr == A_TRIG);
  assign wr.stat = wr_any & (addr == A_STAT);
  assign wr.en   = wr_any & (addr == A_EN);
  assign wr.dis  = wr_any & (addr == A_DIS);

  // gather the sparse bus bits into a dense channel vector
  for (genvar k = 0; k < NCH; k++) begin : g_gather
    localparam int P = nth_set(VALID_MASK, k);
    assign wch[k] = wdata[P];
  end

  logic unused_rsv;
  assign unused_rsv = ^(wdata & ~VALID_MASK);

endmodule

// File: rtl/ipi_irq_core.sv
module ipi_irq_core
  import ipi_pkg::*;
#(
  parameter int NCH = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  wr_sel_t        wr,
  input  logic [NCH-1:0] wch,
  input  logic [NCH-1:0] irq_in,
  input  logic [NCH-1:0] obs_in,
  output logic [NCH-1:0] trig_q,
  output logic [NCH-1:0] sts_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] obs_q,
  output logic           irq_q
);

  logic [NCH-1:0] clr;
  logic [NCH-1:0] sts_n;
  logic [NCH-1:0] mask_n;

  always_comb begin
    clr    = wr.stat ? wch : '0;
    // an incoming request beats a clear on the same edge
    sts_n  = (sts_q & ~clr) | irq_in;
    mask_n = mask_q;
    if (wr.en)  mask_n = mask_n & ~wch;
    if (wr.dis) mask_n = mask_n | wch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      sts_q  <= '0;
      mask_q <= '1;
      obs_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      trig_q <= wr.trig ? wch : '0;
      sts_q  <= sts_n;
      mask_q <= mask_n;
      obs_q  <= obs_in;
      irq_q  <= |(sts_n & ~mask_n);
    end
  end

endmodule

// File: rtl/ipi_spread.sv
module ipi_spread
  import ipi_pkg::*;
#(
  parameter logic [BUS_W-1:0] VALID_MASK = 32'h0F0F0301,
  localparam int             NCH        = count_set(VALID_MASK)
) (
  input  logic [NCH-1:0]   ch,
  output logic [BUS_W-1:0] bus
);

  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    if (VALID_MASK[b]) begin : g_used
      assign bus[b] = ch[rank_of(VALID_MASK, b)];
    end else begin : g_rsv
      assign bus[b] = 1'b0;
    end
  end

endmodule

// File: rtl/ipi_readback.sv
module ipi_readback
  import ipi_pkg::*;
#(
  parameter int              ADDR_W     = 3,
  parameter logic [BUS_W-1:0] VALID_MASK = 32'h0F0F0301,
  localparam int             NCH        = count_set(VALID_MASK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    sts,
  input  logic [NCH-1:0]    mask,
  input  logic [NCH-1:0]    obs,
  output logic [BUS_W-1:0]  rdata
);

  localparam logic [ADDR_W-1:0] A_OBS  = ADDR_W'(W_OBS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(W_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(W_MASK);

  logic [BUS_W-1:0] sts_bus;
  logic [BUS_W-1:0] mask_bus;
  logic [BUS_W-1:0] obs_bus;
  logic [BUS_W-1:0] rd_mux;

  ipi_spread #(.VALID_MASK(VALID_MASK)) u_sp_sts  (.ch(sts),  .bus(sts_bus));
  ipi_spread #(.VALID_MASK(VALID_MASK)) u_sp_mask (.ch(mask), .bus(mask_bus));
  ipi_spread #(.VALID_MASK(VALID_MASK)) u_sp_obs  (.ch(obs),  .bus(obs_bus));

  always_comb begin
    unique case (addr)
      A_OBS:   rd_mux = obs_bus;
      A_STAT:  rd_mux = sts_bus;
      A_MASK:  rd_mux = mask_bus;
      default: rd_mux = '0;   // trigger, aliases and holes
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int              ADDR_W     = 3,
  parameter logic [BUS_W-1:0] VALID_MASK = 32'h0F0F0301,
  localparam int             NCH        = count_set(VALID_MASK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    trig_out,
  input  logic [NCH-1:0]    irq_in,
  input  logic [NCH-1:0]    obs_in,
  output logic [NCH-1:0]    obs_out,
  output logic              irq_out
);

  wr_sel_t        wr;
  logic           rd_en;
  logic [NCH-1:0] wch;
  logic [NCH-1:0] sts_w;
  logic [NCH-1:0] mask_w;
  logic [NCH-1:0] obs_w;

  ipi_bus_decode #(.ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)) u_dec (
    .sel   (bus_sel),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .wr    (wr),
    .rd_en (rd_en),
    .wch   (wch)
  );

  ipi_irq_core #(.NCH(NCH)) u_core (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr),
    .wch    (wch),
    .irq_in (irq_in),
    .obs_in (obs_in),
    .trig_q (trig_out),
    .sts_q  (sts_w),
    .mask_q (mask_w),
    .obs_q  (obs_w),
    .irq_q  (irq_out)
  );

  ipi_readback #(.ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)) u_rb (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (bus_addr),
    .sts   (sts_w),
    .mask  (mask_w),
    .obs   (obs_w),
    .rdata (bus_rdata)
  );

  assign obs_out = sts_w;

endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk
  import ipi_pkg::*;
#(
  parameter int              ADDR_W     = 3,
  parameter logic [BUS_W-1:0] VALID_MASK = 32'h0F0F0301,
  localparam int             NCH        = count_set(VALID_MASK)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NCH-1:0]    trig_out,
  input logic [NCH-1:0]    irq_in,
  input logic [NCH-1:0]    obs_out,
  input logic [NCH-1:0]    mask_w,
  input logic              irq_out
);

  logic wr_trig;
  logic wr_stat;
  assign wr_trig = bus_sel & bus_we & (bus_addr == ADDR_W'(W_TRIG));
  assign wr_stat = bus_sel & bus_we & (bus_addr == ADDR_W'(W_STAT));

  // R3: no trigger pulse without a trigger write on the previous edge
  p_trig_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_trig |=> (trig_out == '0));

  // R4: a request is pending after the edge that saw it
  p_sticky_set_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((obs_out & $past(irq_in)) == $past(irq_in)));

  // R5: without a pending-word write no bit is lost
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((obs_out & $past(obs_out)) == $past(obs_out)));

  // R9: combined output matches pending and mask
  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(obs_out & ~mask_w));

  // R12: reserved read bits stay zero
  p_rsv_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~VALID_MASK) == '0);

endmodule

bind ipi_mailbox ipi_mailbox_chk #(.ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .trig_out  (trig_out),
  .irq_in    (irq_in),
  .obs_out   (obs_out),
  .mask_w    (mask_w),
  .irq_out   (irq_out)
);

// File: tb/sim_ipi_mailbox.sv
module sim_ipi_mailbox;

  localparam int NCH = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] trig_out;
  logic [NCH-1:0] irq_in = '0;
  logic [NCH-1:0] obs_in = '0;
  logic [NCH-1:0] obs_out;
  logic        irq_out;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ipi_mailbox u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_out(trig_out), .irq_in(irq_in), .obs_in(obs_in),
    .obs_out(obs_out), .irq_out(irq_out)
  );

  // channel k sits at bus bit pos[k]
  function automatic logic [31:0] to_bus(input logic [NCH-1:0] c);
    int pos [NCH] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < NCH; k++) v[pos[k]] = c[k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_irq(input logic [NCH-1:0] c);
    @(negedge clk);
    irq_in = c;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 trig_out", {21'b0, trig_out}, 32'h0);
    chk("R1 obs_out", {21'b0, obs_out}, 32'h0);
    bus_read(3'd5, d); chk("R1 mask word", d, 32'h0F0F0301);
    bus_read(3'd4, d); chk("R1 pending word", d, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    bus_read(3'd2, d); chk("R2 hole word 2", d, 32'h0);
    bus_read(3'd3, d); chk("R2 hole word 3", d, 32'h0);
    bus_read(3'd6, d); chk("R8 unmask reads 0", d, 32'h0);
    bus_read(3'd7, d); chk("R8 mask-set reads 0", d, 32'h0);
  endtask

  task automatic t_trigger;
    logic [31:0] d;
    bus_write(3'd0, 32'hFFFF_FFFF);
    chk("R3 all channels pulse", {21'b0, trig_out}, 32'h7FF);
    @(negedge clk);
    chk("R3 pulse ends", {21'b0, trig_out}, 32'h0);
    bus_write(3'd0, 32'h0002_0000);   // bit 17 -> channel 4
    chk("R3 single channel", {21'b0, trig_out}, 32'h010);
    @(negedge clk);
    chk("R3 single ends", {21'b0, trig_out}, 32'h0);
    bus_write(3'd0, 32'hF0F0_FCFE);   // reserved bits only
    chk("R12 reserved trigger bits", {21'b0, trig_out}, 32'h0);
    bus_read(3'd0, d); chk("R3 trigger reads 0", d, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    pulse_irq(11'h005);   // channels 0 and 2
    chk("R11 obs_out mirror", {21'b0, obs_out}, 32'h005);
    chk("R9 masked no irq", {31'b0, irq_out}, 32'h0);
    bus_read(3'd4, d); chk("R4 pending sticky", d, 32'h0000_0201);
    bus_write(3'd6, 32'h0000_0200);   // unmask channel 2
    chk("R9 irq on unmask", {31'b0, irq_out}, 32'h1);
    bus_read(3'd5, d); chk("R8 unmask clears", d, 32'h0F0F0101);
    bus_write(3'd4, 32'h0);
    bus_read(3'd4, d); chk("R5 zero write keeps", d, 32'h0000_0201);
    bus_write(3'd4, 32'h0000_0200);
    chk("R9 irq drops on clear", {31'b0, irq_out}, 32'h0);
    chk("R5 clear one bit", {21'b0, obs_out}, 32'h001);
    bus_write(3'd5, 32'h0);
    bus_read(3'd5, d); chk("R7 mask not writable", d, 32'h0F0F0101);
    bus_write(3'd7, 32'h0000_0200);
    bus_read(3'd5, d); chk("R8 mask-set sets", d, 32'h0F0F0301);
    bus_write(3'd4, 32'hFFFF_FFFF);
    chk("R5 clear all", {21'b0, obs_out}, 32'h0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    irq_in = 11'h001;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h1;
    @(negedge clk);
    irq_in = '0; bus_sel = 1'b0; bus_we = 1'b0;
    chk("R6 set beats clear", {21'b0, obs_out}, 32'h001);
    bus_write(3'd4, 32'h1);
    chk("R6 later clear works", {21'b0, obs_out}, 32'h000);
  endtask

  task automatic t_all_and_obs;
    logic [31:0] d;
    pulse_irq(11'h7FF);
    bus_read(3'd4, d); chk("R12 pending only valid bits", d, 32'h0F0F0301);
    bus_write(3'd6, 32'hFFFF_FFFF);
    chk("R9 irq all unmasked", {31'b0, irq_out}, 32'h1);
    bus_read(3'd5, d); chk("R8 all unmasked", d, 32'h0);
    bus_write(3'd4, 32'hFFFF_FFFF);
    chk("R9 irq clears", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    obs_in = 11'h555;
    bus_read(3'd1, d); chk("R10 peer levels", d, to_bus(11'h555));
    bus_write(3'd1, 32'h0);
    bus_read(3'd1, d); chk("R10 not writable", d, to_bus(11'h555));
    obs_in = 11'h2AA;
    @(negedge clk);
    bus_read(3'd1, d); chk("R10 follows input", d, to_bus(11'h2AA));
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_map;
    t_trigger;
    t_status;
    t_set_wins;
    t_all_and_obs;
    done = 1'b1;
    finish_up;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up;
    end
  end

endmodule